// File: doc/BRIEF.md
# Phase-Encoded Bit-Serial Link Receiver

This block terminates two synchronous three-wire links, A and B, where each wire set (marker, value, return) carries one bit per symbol. A new symbol is recognised only when the link's phase changes. The phase is the exclusive-or of the three wires. The marker wire sorts each symbol into one of two kinds. With the marker low the symbol is a data bit, and with the marker high it is a context-ID bit. In both kinds the bit value is carried on the value wire.

Data symbols are forwarded to the downstream logic function only while neither link has its marker raised. Context-ID symbols arrive on link A. They are shifted in most significant bit first. Each one is acknowledged to the sender with a one-cycle pulse. When the last bit of the ID has been captured, the assembled ID is placed on a parallel output and a completion pulse is raised. Symbols arriving on link B with the marker high are never taken as ID bits. Their only effect is to hold back data.

Top module: `cvr_link_rx`

## Requirements
- R1: After reset, all outputs are 0. Both internal phase references are 0 and the ID bit count is 0.
- R2: A link presents a new symbol only in a cycle where marker xor value xor return differs from the phase seen at the previous edge. If the wires toggle but the phase does not change (for example, value and return flip together), nothing happens.
- R3: A new symbol on link A with marker 0, sampled while link B's marker is also 0, gives a one-cycle pulse on `a_dstb` in the next cycle. In that same cycle `a_dv` shows the value wire and `a_dr` shows the return wire. Both hold these values until the next accepted data symbol on A.
- R4: The same rule as R3 applies to link B, using `b_dstb`, `b_dv` and `b_dr`, gated by link A's marker being 0.
- R5: A data symbol on one link is dropped if the other link's marker is 1 in the same cycle. No strobe is given and the held data outputs do not change. The phase reference of the link still advances, so the symbol is consumed and not replayed.
- R6: Each new symbol on link A with marker 1 gives a one-cycle pulse on `a_ack` in the cycle after it is detected.
- R7: ID bits are shifted in most significant bit first. When the third bit is captured, `ctx_id` takes the assembled ID and `id_done` pulses in the same cycle as that bit's acknowledge. For example, the bits 0, 1, 1 give ID 3.
- R8: `ctx_id` keeps its value between completions. A new data symbol on link A (marker 0) while an ID is only partly received aborts the ID. The count restarts, and the next three ID bits form a whole new ID.
- R9: A new symbol on link B with marker 1 gives no acknowledge and leaves `ctx_id` and `id_done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_c | input | 1 | Link A marker wire (1 = ID bit) |
| a_v | input | 1 | Link A value wire |
| a_r | input | 1 | Link A return wire |
| b_c | input | 1 | Link B marker wire |
| b_v | input | 1 | Link B value wire |
| b_r | input | 1 | Link B return wire |
| a_ack | output | 1 | Acknowledge pulse for an ID bit taken on link A |
| a_dstb | output | 1 | New data from link A |
| a_dv | output | 1 | Held value bit from link A |
| a_dr | output | 1 | Held return bit from link A |
| b_dstb | output | 1 | New data from link B |
| b_dv | output | 1 | Held value bit from link B |
| b_dr | output | 1 | Held return bit from link B |
| ctx_id | output | ID_W | Last complete context ID |
| id_done | output | 1 | Pulse when a full ID has been captured |

## Verification
Several functions of this block can land on the same clock edge. The hardest case is the final ID bit on link A arriving in the same cycle as a data symbol on link B. That one edge must give the acknowledge and the completion pulse together, and it must drop the B symbol because A's marker is high. The bench provokes this collision on purpose. It also stacks ID bits on consecutive cycles and mixes in a long pseudo-random stretch of symbols and phase-neutral wire flips on both links. A behavioural model predicts every output on every clock, and any difference between the block and the model is judged a failure.

// File: rtl/cvr_link_rx.sv
module cvr_link_rx #(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_c,
  input  logic            a_v,
  input  logic            a_r,
  input  logic            b_c,
  input  logic            b_v,
  input  logic            b_r,
  output logic            a_ack,
  output logic            a_dstb,
  output logic            a_dv,
  output logic            a_dr,
  output logic            b_dstb,
  output logic            b_dv,
  output logic            b_dr,
  output logic [ID_W-1:0] ctx_id,
  output logic            id_done
);

  localparam int CNT_W = $clog2(ID_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ID_W - 1);

  logic            ph_a, ph_b;
  logic [ID_W-1:0] sr;
  logic [CNT_W-1:0] cnt;

  wire cur_a  = a_c ^ a_v ^ a_r;
  wire cur_b  = b_c ^ b_v ^ b_r;
  wire new_a  = cur_a != ph_a;
  wire new_b  = cur_b != ph_b;
  wire id_sym = new_a && a_c;
  wire dat_a  = new_a && !a_c && !b_c;
  wire dat_b  = new_b && !b_c && !a_c;
  wire [ID_W-1:0] sr_nx = {sr[ID_W-2:0], a_v};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_a    <= 1'b0;
      ph_b    <= 1'b0;
      sr      <= '0;
      cnt     <= '0;
      ctx_id  <= '0;
      id_done <= 1'b0;
      a_ack   <= 1'b0;
    end else begin
      ph_a    <= cur_a;
      ph_b    <= cur_b;
      a_ack   <= id_sym;
      id_done <= 1'b0;
      if (id_sym) begin
        sr <= sr_nx;
        if (cnt == LAST) begin
          cnt     <= '0;
          ctx_id  <= sr_nx;
          id_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (new_a) begin
        cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_dstb <= 1'b0;
      a_dv   <= 1'b0;
      a_dr   <= 1'b0;
      b_dstb <= 1'b0;
      b_dv   <= 1'b0;
      b_dr   <= 1'b0;
    end else begin
      a_dstb <= dat_a;
      b_dstb <= dat_b;
      if (dat_a) begin
        a_dv <= a_v;
        a_dr <= a_r;
      end
      if (dat_b) begin
        b_dv <= b_v;
        b_dr <= b_r;
      end
    end
  end

  assert_ack_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
    a_ack |-> $past(a_c));
  assert_done_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_done |-> a_ack);
  assert_ctx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !id_done |-> $stable(ctx_id));
  assert_a_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_dstb |-> ($past(!b_c) && $past(!a_c)));
  assert_b_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    b_dstb |-> ($past(!a_c) && $past(!b_c)));
  assert_a_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !a_dstb |-> $stable({a_dv, a_dr}));
  assert_b_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !b_dstb |-> $stable({b_dv, b_dr}));
  assert_no_data_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_ack |-> !(a_dstb || b_dstb));

endmodule

// File: tb/cvr_link_rx_tb.sv
`timescale 1ns/100ps
module cvr_link_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_c = 0, a_v = 0, a_r = 0, b_c = 0, b_v = 0, b_r = 0;
  logic a_ack, a_dstb, a_dv, a_dr, b_dstb, b_dv, b_dr, id_done;
  logic [2:0] ctx_id;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cvr_link_rx #(.ID_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_c(a_c), .a_v(a_v), .a_r(a_r), .b_c(b_c), .b_v(b_v), .b_r(b_r),
    .a_ack(a_ack), .a_dstb(a_dstb), .a_dv(a_dv), .a_dr(a_dr),
    .b_dstb(b_dstb), .b_dv(b_dv), .b_dr(b_dr),
    .ctx_id(ctx_id), .id_done(id_done));

  // reference model state
  bit m_pha, m_phb, m_ack, m_done, m_astb, m_adv, m_adr, m_bstb, m_bdv, m_bdr;
  int m_sr, m_cnt, m_ctx;

  always @(posedge clk) begin
    bit pa, pb, na, nb;
    if (!rst_n) begin
      m_pha = 0; m_phb = 0; m_ack = 0; m_done = 0; m_astb = 0; m_bstb = 0;
      m_adv = 0; m_adr = 0; m_bdv = 0; m_bdr = 0; m_sr = 0; m_cnt = 0; m_ctx = 0;
    end else begin
      pa = a_c ^ a_v ^ a_r;
      pb = b_c ^ b_v ^ b_r;
      na = pa != m_pha;
      nb = pb != m_phb;
      m_ack  = na && a_c;
      m_done = 0;
      m_astb = na && !a_c && !b_c;
      m_bstb = nb && !b_c && !a_c;
      if (m_astb) begin m_adv = a_v; m_adr = a_r; end
      if (m_bstb) begin m_bdv = b_v; m_bdr = b_r; end
      if (na && a_c) begin
        m_sr = ((m_sr << 1) | int'(a_v)) & 7;
        m_cnt++;
        if (m_cnt == 3) begin m_ctx = m_sr; m_done = 1; m_cnt = 0; end
      end else if (na) begin
        m_cnt = 0;
      end
      m_pha = pa;
      m_phb = pb;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 reset outputs", {a_ack, a_dstb, a_dv, a_dr, b_dstb, b_dv, b_dr, id_done, ctx_id}, 0);
    end else begin
      chk("R3 a_dstb", a_dstb, m_astb);
      chk("R3 a_dv/a_dr", {a_dv, a_dr}, {m_adv, m_adr});
      chk("R4 b_dstb", b_dstb, m_bstb);
      chk("R4 b_dv/b_dr", {b_dv, b_dr}, {m_bdv, m_bdr});
      chk("R6 a_ack", a_ack, m_ack);
      chk("R7 id_done", id_done, m_done);
      chk("R7 ctx_id", ctx_id, m_ctx);
    end
  end

  // sender-side phase per link
  bit tpa = 0, tpb = 0;

  // one cycle of stimulus; ea/eb select a new symbol on that link, ga/gb a phase-neutral flip
  task automatic step(input bit ea, input bit ca, input bit va,
                      input bit eb, input bit cb, input bit vb,
                      input bit ga = 0, input bit gb = 0);
    @(negedge clk);
    #0.5;
    if (ea) begin tpa = ~tpa; a_c = ca; a_v = va; a_r = ca ^ va ^ tpa; end
    else if (ga) begin a_v = ~a_v; a_r = ~a_r; end
    if (eb) begin tpb = ~tpb; b_c = cb; b_v = vb; b_r = cb ^ vb ^ tpb; end
    else if (gb) begin b_v = ~b_v; b_r = ~b_r; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic id_a(input bit [2:0] id, input int gap);
    for (int i = 2; i >= 0; i--) begin
      step(1, 1, id[i], 0, 0, 0);
      idle(gap);
    end
  endtask

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    #0.5 rst_n = 1'b1;
    idle(2);
    // R3: data on link A with several values
    step(1, 0, 1, 0, 0, 0); step(1, 0, 0, 0, 0, 0); idle(1); step(1, 0, 1, 0, 0, 0);
    // R4: data on link B, then both links together
    step(0, 0, 0, 1, 0, 1); step(0, 0, 0, 1, 0, 0); step(1, 0, 0, 1, 0, 1);
    // R2: phase-neutral wire flips on both links are ignored
    step(0, 0, 0, 0, 0, 0, 1, 1); step(0, 0, 0, 0, 0, 0, 1, 0); idle(2);
    // R7: ID 0,1,1 -> 3 with gaps; return to data afterwards
    id_a(3'b011, 1);
    step(1, 0, 1, 0, 0, 0);
    // R5/R7: third ID bit collides with a data symbol on B, which is dropped
    step(1, 1, 1, 0, 0, 0); step(1, 1, 0, 0, 0, 0);
    step(1, 1, 1, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0); idle(2);
    // R7: back-to-back ID 1,1,0 -> 6
    id_a(3'b110, 0);
    step(1, 0, 1, 0, 0, 0); idle(1);
    // R8: partial ID aborted by A data, then a full ID 0,1,0 -> 2
    step(1, 1, 1, 0, 0, 0); step(1, 1, 1, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
    id_a(3'b010, 0);
    step(1, 0, 0, 0, 0, 0); idle(2);
    // R9: ID-marked symbols on B: no ack, ctx_id unchanged; R5: A data blocked meanwhile
    step(0, 0, 0, 1, 1, 1); step(1, 0, 1, 1, 1, 0); step(1, 0, 0, 1, 1, 1);
    step(0, 0, 0, 1, 0, 1); idle(2);
    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1] & lfsr[2], lfsr[3], lfsr[4], lfsr[5] & lfsr[6] & lfsr[7], lfsr[8],
           lfsr[9], lfsr[10]);
    end
    idle(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule